// File: doc/BRIEF.md
# Single/Double Precision Format Converter

This block converts a floating-point value between single and double precision. Both operands sit in a 64-bit floating-point register format. In the narrowing direction the double-precision source is rounded to single precision, and the result is returned NaN-boxed: the single value is in the low 32 bits and the upper 32 bits are all ones. In the widening direction the block first checks that the single-precision operand is correctly boxed, and then produces the exact double-precision value.

The block handles zeros, subnormals on both sides, infinities and NaNs. It raises invalid, overflow, underflow and inexact flags. It is a single registered stage: an operand presented with `in_valid` appears on `result` and `flags` one clock later, with `out_valid` set. The surrounding pipeline supplies the direction and the rounding mode for each operation.

Top module: `fp_width_conv`

## Requirements
- R1: With `to_single`=1, `result[63:32]` is all ones and `result[31:0]` holds the single-precision value, for every input class.
- R2: Narrowing rounds as set by `rnd_mode`: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away from zero, and 5 to 7 behave as nearest-even. A discarded nonzero part sets inexact. The flags bits are {invalid, overflow, underflow, inexact} from bit 3 down to bit 0.
- R3: A narrowed magnitude that is too large after rounding produces either infinity or the largest finite single value 0x7F7FFFFF with the input's sign, and sets overflow and inexact. Nearest modes give infinity. Toward zero gives the largest finite value. Toward minus infinity gives infinity only for negative inputs. Toward plus infinity gives infinity only for positive inputs.
- R4: Double inputs below the single normal range, including double subnormals, are shifted into the single subnormal range with full sticky collection and then rounded. Underflow is raised when the pre-rounding value is below 2^-126 and the result is inexact. Exact tiny results raise no flag.
- R5: Any NaN result is the canonical NaN: 0x7FC00000 for single, and 0x7FF8000000000000 for double. A signaling NaN input (quiet bit clear) sets invalid. A quiet NaN input sets no flag.
- R6: With `to_single`=0 the result is the exact double value and only invalid can be raised. Single subnormals come out as normalized doubles. `rnd_mode` has no effect in this direction.
- R7: In widening, an operand whose `src[63:32]` is not all ones is treated as the single canonical NaN. It yields 0x7FF8000000000000 with no flags, whatever its low 32 bits hold.
- R8: `out_valid` follows `in_valid` by exactly one clock. Reset clears `out_valid`, `result` and `flags`.
- R9: Signed zeros and infinities convert exactly in both directions, keep their sign and raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| to_single | input | 1 | 1 selects double to single, 0 selects single to double |
| rnd_mode | input | 3 | Rounding mode, used only when narrowing |
| src | input | 64 | Source operand in register format |
| out_valid | output | 1 | Result present |
| result | output | 64 | Converted value in register format |
| flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
All conversion state lives in the single output register, so a wrong shift amount, guard or sticky bit, or exponent bias shows up on `result` in the cycle right after the operand is accepted. No later operation can mask it. Halfway operands in every rounding mode expose a wrong increment decision as a one-ulp error. Operands on the subnormal boundary expose a wrong denormalization shift as a wrong exponent field or a missing underflow flag. Badly boxed and signaling operands show a wrong box check or quiet-bit test directly on the NaN pattern and the invalid bit.

// File: rtl/fp_width_conv.sv
module fp_width_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        to_single,
  input  logic [2:0]  rnd_mode,
  input  logic [63:0] src,
  output logic        out_valid,
  output logic [63:0] result,
  output logic [3:0]  flags
);

  localparam logic [31:0] SNGL_QNAN = 32'h7FC0_0000;
  localparam logic [63:0] DBL_QNAN  = 64'h7FF8_0000_0000_0000;

  // narrowing path
  logic        d_sign;
  logic [10:0] d_exp;
  logic [51:0] d_frac;
  logic        d_exp_max, d_zero;
  logic [52:0] d_sig;
  logic signed [12:0] n_exp;
  logic [4:0]  n_sh;
  logic [78:0] n_ext;
  logic        n_guard, n_sticky, n_lsb, n_inc, n_inexact, n_tiny;
  logic [7:0]  n_efield;
  logic [31:0] n_sum;
  logic        n_ovf, n_to_inf;
  logic [31:0] n_val;
  logic [3:0]  n_flags;

  assign d_sign    = src[63];
  assign d_exp     = src[62:52];
  assign d_frac    = src[51:0];
  assign d_exp_max = &d_exp;
  assign d_zero    = (d_exp == 11'd0) && (d_frac == 52'd0);
  assign d_sig     = {|d_exp, d_frac};
  assign n_exp     = $signed({2'b00, (d_exp == 11'd0) ? 11'd1 : d_exp}) - 13'sd896;

  always_comb begin
    if (n_exp >= 13'sd1)        n_sh = 5'd0;
    else if (n_exp <= -13'sd25) n_sh = 5'd26;
    else                        n_sh = 5'(13'sd1 - n_exp);
  end

  assign n_ext     = {d_sig, 26'd0} >> n_sh;
  assign n_lsb     = n_ext[55];
  assign n_guard   = n_ext[54];
  assign n_sticky  = |n_ext[53:0];
  assign n_inexact = n_guard | n_sticky;
  assign n_tiny    = (n_sh != 5'd0);
  assign n_efield  = n_tiny ? 8'd0 : n_exp[7:0];

  always_comb begin
    case (rnd_mode)
      3'd1:    n_inc = 1'b0;
      3'd2:    n_inc = d_sign & n_inexact;
      3'd3:    n_inc = ~d_sign & n_inexact;
      3'd4:    n_inc = n_guard;
      default: n_inc = n_guard & (n_sticky | n_lsb);
    endcase
  end

  always_comb begin
    case (rnd_mode)
      3'd1:    n_to_inf = 1'b0;
      3'd2:    n_to_inf = d_sign;
      3'd3:    n_to_inf = ~d_sign;
      default: n_to_inf = 1'b1;
    endcase
  end

  assign n_sum = {1'b0, n_efield, n_ext[77:55]} + {31'd0, n_inc};
  assign n_ovf = (n_exp >= 13'sd255) || (n_sum[30:23] == 8'hFF);

  always_comb begin
    n_flags = 4'b0000;
    if (d_exp_max) begin
      if (d_frac != 52'd0) begin
        n_val   = SNGL_QNAN;
        n_flags = {~d_frac[51], 3'b000};
      end else begin
        n_val = {d_sign, 8'hFF, 23'd0};
      end
    end else if (d_zero) begin
      n_val = {d_sign, 31'd0};
    end else if (n_ovf) begin
      n_val   = n_to_inf ? {d_sign, 8'hFF, 23'd0} : {d_sign, 8'hFE, 23'h7F_FFFF};
      n_flags = 4'b0101;
    end else begin
      n_val   = {d_sign, n_sum[30:0]};
      n_flags = {2'b00, n_tiny & n_inexact, n_inexact};
    end
  end

  // widening path
  logic        s_boxed;
  logic [31:0] s_word;
  logic        s_sign;
  logic [7:0]  s_exp;
  logic [22:0] s_frac;
  logic [4:0]  w_lz;
  logic [22:0] w_nfrac;
  logic [10:0] w_sub_exp;
  logic [63:0] w_val;
  logic [3:0]  w_flags;

  assign s_boxed = &src[63:32];
  assign s_word  = s_boxed ? src[31:0] : SNGL_QNAN;
  assign s_sign  = s_word[31];
  assign s_exp   = s_word[30:23];
  assign s_frac  = s_word[22:0];

  always_comb begin
    w_lz = 5'd0;
    for (int i = 0; i < 23; i++)
      if (s_frac[i]) w_lz = 5'(22 - i);
  end

  assign w_nfrac   = s_frac << (w_lz + 5'd1);
  assign w_sub_exp = 11'd896 - {6'd0, w_lz};

  always_comb begin
    w_flags = 4'b0000;
    if (&s_exp) begin
      if (s_frac != 23'd0) begin
        w_val   = DBL_QNAN;
        w_flags = {~s_frac[22], 3'b000};
      end else begin
        w_val = {s_sign, 11'h7FF, 52'd0};
      end
    end else if (s_exp == 8'd0) begin
      if (s_frac == 23'd0) w_val = {s_sign, 63'd0};
      else                 w_val = {s_sign, w_sub_exp, w_nfrac, 29'd0};
    end else begin
      w_val = {s_sign, {3'd0, s_exp} + 11'd896, s_frac, 29'd0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 64'd0;
      flags     <= 4'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= to_single ? {32'hFFFF_FFFF, n_val} : w_val;
        flags  <= to_single ? n_flags : w_flags;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R8

  AST_BOX_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(to_single) |-> result[63:32] == 32'hFFFF_FFFF); // R1

  AST_WIDEN_NO_ROUND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(to_single) |-> flags[2:0] == 3'b000); // R6

  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[2] |-> flags[0]); // R3

  AST_UF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[1] |-> flags[0] && !flags[2]); // R4

  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(to_single) && result[30:23] == 8'hFF && result[22:0] != 23'd0
      |-> result[31:0] == SNGL_QNAN); // R5

  AST_INVALID_ONLY_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[3] |-> flags[2:0] == 3'b000); // R5

endmodule

// File: tb/fp_width_conv_tb.sv
module fp_width_conv_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        to_single = 1'b0;
  logic [2:0]  rnd_mode = 3'd0;
  logic [63:0] src = 64'd0;
  logic        out_valid;
  logic [63:0] result;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [63:0] res;
    logic [3:0]  fl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  fp_width_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .to_single(to_single),
    .rnd_mode(rnd_mode), .src(src), .out_valid(out_valid),
    .result(result), .flags(flags)
  );

  localparam logic [63:0] BOX = 64'hFFFF_FFFF_0000_0000;
  localparam logic [63:0] DQN = 64'h7FF8_0000_0000_0000;

  task automatic send(input logic dir, input logic [2:0] rm, input logic [63:0] s,
                      input logic [63:0] er, input logic [3:0] ef, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    to_single = dir;
    rnd_mode  = rm;
    src       = s;
    exp_q.push_back('{res: er, fl: ef});
    tag_q.push_back(tag);
  endtask

  task automatic nar(input logic [2:0] rm, input logic [63:0] s, input logic [31:0] e32,
                     input logic [3:0] ef, input string tag);
    send(1'b1, rm, s, BOX | {32'd0, e32}, ef, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected out_valid: got result %h, expected no output", result);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (result !== e.res || flags !== e.fl) begin
          fails++;
          $display("FAIL %s: result %h flags %b, expected %h flags %b", t, result, flags, e.res, e.fl);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || flags !== 4'd0) begin
      fails++;
      $display("FAIL R8 reset state: got %b %h %b, expected 0 0 0", out_valid, result, flags);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // narrowing: basics, zeros, infinities
    nar(3'd0, 64'h3FF0_0000_0000_0000, 32'h3F80_0000, 4'b0000, "R1 narrow 1.0");
    nar(3'd0, 64'h8000_0000_0000_0000, 32'h8000_0000, 4'b0000, "R9 narrow -0");
    nar(3'd0, 64'h0000_0000_0000_0000, 32'h0000_0000, 4'b0000, "R9 narrow +0");
    nar(3'd1, 64'h7FF0_0000_0000_0000, 32'h7F80_0000, 4'b0000, "R9 narrow +inf");
    nar(3'd0, 64'hFFF0_0000_0000_0000, 32'hFF80_0000, 4'b0000, "R9 narrow -inf");
    // NaNs
    nar(3'd0, 64'h7FF0_0000_0000_0001, 32'h7FC0_0000, 4'b1000, "R5 narrow sNaN");
    nar(3'd0, 64'hFFF8_0000_0000_0123, 32'h7FC0_0000, 4'b0000, "R5 narrow qNaN");
    // halfway, even lsb, positive
    nar(3'd0, 64'h3FF0_0000_1000_0000, 32'h3F80_0000, 4'b0001, "R2 half+ RNE");
    nar(3'd1, 64'h3FF0_0000_1000_0000, 32'h3F80_0000, 4'b0001, "R2 half+ RTZ");
    nar(3'd2, 64'h3FF0_0000_1000_0000, 32'h3F80_0000, 4'b0001, "R2 half+ RDN");
    nar(3'd3, 64'h3FF0_0000_1000_0000, 32'h3F80_0001, 4'b0001, "R2 half+ RUP");
    nar(3'd4, 64'h3FF0_0000_1000_0000, 32'h3F80_0001, 4'b0001, "R2 half+ RMM");
    // halfway, negative
    nar(3'd0, 64'hBFF0_0000_1000_0000, 32'hBF80_0000, 4'b0001, "R2 half- RNE");
    nar(3'd1, 64'hBFF0_0000_1000_0000, 32'hBF80_0000, 4'b0001, "R2 half- RTZ");
    nar(3'd2, 64'hBFF0_0000_1000_0000, 32'hBF80_0001, 4'b0001, "R2 half- RDN");
    nar(3'd3, 64'hBFF0_0000_1000_0000, 32'hBF80_0000, 4'b0001, "R2 half- RUP");
    nar(3'd4, 64'hBFF0_0000_1000_0000, 32'hBF80_0001, 4'b0001, "R2 half- RMM");
    // halfway, odd lsb
    nar(3'd0, 64'h3FF0_0000_3000_0000, 32'h3F80_0002, 4'b0001, "R2 half odd RNE");
    nar(3'd1, 64'h3FF0_0000_3000_0000, 32'h3F80_0001, 4'b0001, "R2 half odd RTZ");
    nar(3'd7, 64'h3FF0_0000_3000_0000, 32'h3F80_0002, 4'b0001, "R2 half odd code7");
    // sticky only
    nar(3'd0, 64'h3FF0_0000_0040_0000, 32'h3F80_0000, 4'b0001, "R2 sticky RNE");
    nar(3'd3, 64'h3FF0_0000_0040_0000, 32'h3F80_0001, 4'b0001, "R2 sticky RUP");
    // overflow
    nar(3'd0, 64'h7FEF_FFFF_FFFF_FFFF, 32'h7F80_0000, 4'b0101, "R3 dmax RNE");
    nar(3'd1, 64'h7FEF_FFFF_FFFF_FFFF, 32'h7F7F_FFFF, 4'b0101, "R3 dmax RTZ");
    nar(3'd3, 64'hFFEF_FFFF_FFFF_FFFF, 32'hFF7F_FFFF, 4'b0101, "R3 -dmax RUP");
    nar(3'd2, 64'hFFEF_FFFF_FFFF_FFFF, 32'hFF80_0000, 4'b0101, "R3 -dmax RDN");
    nar(3'd0, 64'h47EF_FFFF_F000_0000, 32'h7F80_0000, 4'b0101, "R3 round into ovf RNE");
    nar(3'd1, 64'h47EF_FFFF_F000_0000, 32'h7F7F_FFFF, 4'b0001, "R3 near ovf RTZ");
    // subnormal range
    nar(3'd0, 64'h36A0_0000_0000_0000, 32'h0000_0001, 4'b0000, "R4 min subnormal exact");
    nar(3'd0, 64'h3800_0000_0000_0000, 32'h0040_0000, 4'b0000, "R4 2^-127 exact");
    nar(3'd0, 64'h3690_0000_0000_0000, 32'h0000_0000, 4'b0011, "R4 half min sub RNE");
    nar(3'd3, 64'h3690_0000_0000_0000, 32'h0000_0001, 4'b0011, "R4 half min sub RUP");
    nar(3'd4, 64'h3690_0000_0000_0000, 32'h0000_0001, 4'b0011, "R4 half min sub RMM");
    nar(3'd0, 64'h380F_FFFF_E000_0000, 32'h0080_0000, 4'b0011, "R4 round to min normal");
    nar(3'd1, 64'h380F_FFFF_E000_0000, 32'h007F_FFFF, 4'b0011, "R4 below min normal RTZ");
    nar(3'd0, 64'h0000_0000_0000_0001, 32'h0000_0000, 4'b0011, "R4 dbl subnormal RNE");
    nar(3'd3, 64'h0000_0000_0000_0001, 32'h0000_0001, 4'b0011, "R4 dbl subnormal RUP");
    nar(3'd2, 64'h8000_0000_0000_0001, 32'h8000_0001, 4'b0011, "R4 -dbl subnormal RDN");

    // widening
    send(1'b0, 3'd0, 64'hFFFF_FFFF_3F80_0000, 64'h3FF0_0000_0000_0000, 4'b0000, "R6 widen 1.0");
    send(1'b0, 3'd3, 64'hFFFF_FFFF_3F80_0000, 64'h3FF0_0000_0000_0000, 4'b0000, "R6 widen mode ignored");
    send(1'b0, 3'd0, 64'hFFFF_FFFF_8000_0000, 64'h8000_0000_0000_0000, 4'b0000, "R9 widen -0");
    send(1'b0, 3'd0, 64'hFFFF_FFFF_FF80_0000, 64'hFFF0_0000_0000_0000, 4'b0000, "R9 widen -inf");
    send(1'b0, 3'd0, 64'hFFFF_FFFF_7F80_0001, DQN, 4'b1000, "R5 widen sNaN");
    send(1'b0, 3'd0, 64'hFFFF_FFFF_FFC0_0005, DQN, 4'b0000, "R5 widen qNaN");
    send(1'b0, 3'd0, 64'h0000_0000_3F80_0000, DQN, 4'b0000, "R7 unboxed 1.0");
    send(1'b0, 3'd0, 64'hFFFF_FFFE_7F80_0001, DQN, 4'b0000, "R7 unboxed sNaN pattern");
    send(1'b0, 3'd0, 64'hFFFF_FFFF_0000_0001, 64'h36A0_0000_0000_0000, 4'b0000, "R6 widen min subnormal");
    send(1'b0, 3'd0, 64'hFFFF_FFFF_007F_FFFF, 64'h380F_FFFF_C000_0000, 4'b0000, "R6 widen max subnormal");
    send(1'b0, 3'd0, 64'hFFFF_FFFF_7F7F_FFFF, 64'h47EF_FFFF_E000_0000, 4'b0000, "R6 widen max finite");

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 drain: got out_valid %b pending %0d, expected 0 and 0", out_valid, exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule